// File: doc/BRIEF.md
# Self-Reloading Programmable Frequency Divider

This block divides an input clock by a value chosen on a 6-bit input. A counter runs toward its terminal state, and the terminal-count flag is fed straight back as the select between counting and parallel loading. No comparator is involved. The cycle in which the counter sits at terminal count is the cycle in which it reloads the divide value. The output is therefore an active-low strobe, one clock wide, that repeats every `div_i + 1` clocks.

A parameter picks the counting direction. In the down variant the counter loads `div_i` and counts toward all zeros. In the up variant it loads the ones' complement of `div_i` and counts toward all ones. Both variants give the same ratio and the same phase. Synchronous reset loads the preset, so the first period after reset is a full one. A preset of zero leaves the counter at terminal count on every cycle, and the output then stays low for as long as the preset is zero.

Top module: `sr_divider`

## Requirements
- R1: With a preset D from 1 to 63 held steady, successive low cycles of `pulse_n_o` are exactly D+1 clocks apart.
- R2: For a nonzero preset, `pulse_n_o` is low for exactly one clock in each period and is high in the clock after every low cycle.
- R3: In the cycle where `pulse_n_o` is low, the next rising edge reloads the counter from the `div_i` value present at that edge. A preset changed in the middle of a period takes effect only at the next reload. Before that reload, the current period finishes with the old value.
- R4: A preset of 0 keeps `pulse_n_o` low on every clock while it is applied.
- R5: While `rst_i` is high, the counter holds the preset and `pulse_n_o` is high for a nonzero D. After release, `pulse_n_o` goes low after the D-th rising edge that samples `rst_i` low.
- R6: With `COUNT_UP=1`, the counter loads the bitwise complement of D and counts upward to all ones. Its output is cycle-for-cycle identical to the `COUNT_UP=0` variant for the same stimulus.
- R7: Between reloads, every rising edge moves the counter by exactly one step in the configured direction (down: minus 1, up: plus 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset; loads the preset |
| div_i | input | WIDTH | Divide preset D; ratio is D+1 |
| pulse_n_o | output | 1 | Active-low one-clock strobe per divide period |

## Verification
A counter holding a wrong value shows up as a strobe that arrives early or late. The error becomes visible at the very next low cycle of `pulse_n_o`, at most 64 clocks later. A wrong reload or a missed step shifts every later strobe, so an error in the spacing between strobes pins down the faulty period. The bench runs two instances, one per counting direction, on the same preset and checks every cycle of both against the predicted strobe position. An error in the complement loading of the up variant therefore shows up as a phase split between the two outputs.

// File: rtl/sr_divider_pkg.sv
package sr_divider_pkg;
   typedef enum logic {
      SEL_COUNT = 1'b0,
      SEL_LOAD  = 1'b1
   } sel_e;

   localparam int unsigned MIN_WIDTH = 2;
   localparam int unsigned MAX_WIDTH = 16;
endpackage

// File: rtl/sr_divider_preset_map.sv
module sr_divider_preset_map #(
   parameter int unsigned WIDTH    = 6,
   parameter bit          COUNT_UP = 1'b0
) (
   input  logic [WIDTH-1:0] div_i,
   output logic [WIDTH-1:0] load_o
);
   generate
      if (COUNT_UP) begin : g_up
         // distance from ~D to all-ones is D steps
         assign load_o = ~div_i;
      end else begin : g_down
         assign load_o = div_i;
      end
   endgenerate
endmodule

// File: rtl/sr_divider_term_detect.sv
module sr_divider_term_detect #(
   parameter int unsigned WIDTH    = 6,
   parameter bit          COUNT_UP = 1'b0
) (
   input  logic [WIDTH-1:0] cnt_i,
   output logic             term_o
);
   generate
      if (COUNT_UP) begin : g_up
         assign term_o = &cnt_i;
      end else begin : g_down
         assign term_o = ~|cnt_i;
      end
   endgenerate
endmodule

// File: rtl/sr_divider_count_core.sv
module sr_divider_count_core
   import sr_divider_pkg::*;
#(
   parameter int unsigned WIDTH    = 6,
   parameter bit          COUNT_UP = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  sel_e             sel_i,
   input  logic [WIDTH-1:0] load_i,
   output logic [WIDTH-1:0] cnt_o
);
   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] step_d;

   generate
      if (COUNT_UP) begin : g_up
         assign step_d = cnt_q + STEP;
      end else begin : g_down
         assign step_d = cnt_q - STEP;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i || (sel_i == SEL_LOAD)) begin
         cnt_q <= load_i;
      end else begin
         cnt_q <= step_d;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/sr_divider.sv
module sr_divider
   import sr_divider_pkg::*;
#(
   parameter int unsigned WIDTH    = 6,
   parameter bit          COUNT_UP = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] div_i,
   output logic             pulse_n_o
);
   generate
      if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH) begin : g_bad_width
         $error("sr_divider: WIDTH out of supported range");
      end
   endgenerate

   logic [WIDTH-1:0] load_val;
   logic [WIDTH-1:0] cnt_q;
   logic             term;
   sel_e             sel;

   sr_divider_preset_map #(.WIDTH(WIDTH), .COUNT_UP(COUNT_UP)) map_i (
      .div_i  (div_i),
      .load_o (load_val)
   );

   sr_divider_count_core #(.WIDTH(WIDTH), .COUNT_UP(COUNT_UP)) core_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .sel_i  (sel),
      .load_i (load_val),
      .cnt_o  (cnt_q)
   );

   sr_divider_term_detect #(.WIDTH(WIDTH), .COUNT_UP(COUNT_UP)) term_i (
      .cnt_i  (cnt_q),
      .term_o (term)
   );

   // carry-out doubles as the load/count select
   assign sel       = term ? SEL_LOAD : SEL_COUNT;
   assign pulse_n_o = ~term;
endmodule

// File: rtl/sr_divider_chk.sv
module sr_divider_chk #(
   parameter int unsigned WIDTH    = 6,
   parameter bit          COUNT_UP = 1'b0
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic [WIDTH-1:0] div_i,
   input logic             pulse_n_o,
   input logic [WIDTH-1:0] cnt_q
);
   AST_RELOAD_FROM_PRESET: assert property (@(posedge clk_i) disable iff (rst_i)
      !pulse_n_o |=> cnt_q == (COUNT_UP ? ~$past(div_i) : $past(div_i))); // R3

   AST_SINGLE_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      (!pulse_n_o && div_i != '0) |=> pulse_n_o); // R2

   AST_ZERO_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      (!pulse_n_o && div_i == '0) |=> !pulse_n_o); // R4

   AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_n_o |=> cnt_q == (COUNT_UP ? WIDTH'($past(cnt_q) + 1'b1)
                                       : WIDTH'($past(cnt_q) - 1'b1))); // R7
endmodule

bind sr_divider sr_divider_chk #(.WIDTH(WIDTH), .COUNT_UP(COUNT_UP)) chk_i (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .div_i     (div_i),
   .pulse_n_o (pulse_n_o),
   .cnt_q     (cnt_q)
);

// File: tb/sr_divider_tb_top.sv
`timescale 1ns/1ps
module sr_divider_tb_top;
   localparam int W = 6;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] div = '0;
   logic         pn_dn;
   logic         pn_up;
   int           n_chk  = 0;
   int           n_fail = 0;
   int           cyc    = 0;
   bit           done   = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   sr_divider #(.WIDTH(W), .COUNT_UP(1'b0)) dut_i (
      .clk_i(clk), .rst_i(rst), .div_i(div), .pulse_n_o(pn_dn));
   sr_divider #(.WIDTH(W), .COUNT_UP(1'b1)) dut_up_i (
      .clk_i(clk), .rst_i(rst), .div_i(div), .pulse_n_o(pn_up));

   function automatic logic exp_level(int k, int d);
      return (k == d + 1) ? 1'b0 : 1'b1;
   endfunction

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
      end
   endtask

   // caller sits at a negedge inside a low cycle; checks one full period
   task automatic run_period(input int d, input string tag);
      for (int k = 1; k <= d + 1; k++) begin
         @(negedge clk);
         chk(pn_dn, exp_level(k, d), {tag, " down"});
         chk(pn_up, exp_level(k, d), {tag, " up R6"});
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int d;
      void'($urandom(32'h5eed_0136));
      // reset with D=7 (R5)
      div = 7'd7;
      repeat (3) @(negedge clk);
      chk(pn_dn, 1'b1, "R5 high during reset");
      chk(pn_up, 1'b1, "R5 high during reset up");
      rst = 1'b0;
      for (int k = 1; k <= 7; k++) begin
         @(negedge clk);
         chk(pn_dn, (k == 7) ? 1'b0 : 1'b1, "R5 first period");
         chk(pn_up, (k == 7) ? 1'b0 : 1'b1, "R5 first period up");
      end
      run_period(7, "R1 D=7");

      // every preset 1..63, two periods each (R1, R2)
      for (int dd = 1; dd < 64; dd++) begin
         div = W'(dd);
         run_period(dd, "R1 sweep");
         run_period(dd, "R2 sweep");
      end

      // preset zero holds low (R4)
      div = '0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk(pn_dn, 1'b0, "R4 zero preset");
         chk(pn_up, 1'b0, "R4 zero preset up");
      end
      div = W'(9);
      run_period(9, "R4 leave zero");

      // mid-period change waits for reload (R3)
      div = W'(40);
      @(negedge clk);
      chk(pn_dn, 1'b1, "R3 after reload");
      div = W'(5);
      for (int k = 2; k <= 41; k++) begin
         @(negedge clk);
         chk(pn_dn, exp_level(k, 40), "R3 old period kept");
         chk(pn_up, exp_level(k, 40), "R3 old period kept up");
      end
      run_period(5, "R3 new preset");
      run_period(5, "R7 steady");

      // constrained random presets
      for (int i = 0; i < 40; i++) begin
         d = 1 + int'($urandom % 63);
         div = W'(d);
         run_period(d, "R1 random");
      end

      // reset again mid-run with D=0: low during reset (R5/R4)
      rst = 1'b1;
      div = '0;
      repeat (2) @(negedge clk);
      chk(pn_dn, 1'b0, "R5 reset with zero");
      div = W'(3);
      @(negedge clk);
      rst = 1'b0;
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         chk(pn_dn, (k == 3) ? 1'b0 : 1'b1, "R5 second reset");
         chk(pn_up, (k == 3) ? 1'b0 : 1'b1, "R5 second reset up");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule